// File: doc/BRIEF.md
# Four-Channel PWM Controller

This block generates four pulse-width-modulated outputs from a single input clock. It contains four independent timebases, each made of a 16-bit prescaler and an 8-bit step counter. Every period therefore holds 256 steps, and each step lasts as many input clocks as the timebase's divider value. Each output channel compares its own 8-bit duty level against the step counter of one timebase. A 2-bit selector chooses which of the four timebases the channel follows.

Software programs the block through single-cycle register accesses. A write is taken on the clock edge where the strobe is high. Read data is combinational from the address. A channel needs its output enable to drive anything. A per-channel force-high bit holds an enabled output at a constant 1. Changes to a divider or to a duty value act on the running waveform straight away. The current period is not allowed to finish under the old settings.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all four outputs are low.
- R2: Register map, word addresses:
  - Control at 0x00: output enable of channel c at bit c, force-high of channel c at bit 8+c.
  - Run register at 0x04: timebase c may count when bit c is set.
  - Divider c at 0x08+4c: bits 15:0.
  - Duty c at 0x18+4c: level in bits 7:0, timebase select in bits 9:8.
  - Reads return the stored values. Unused bits and unmapped addresses read 0.
- R3: With divider N>0 running and duty D, an enabled channel repeats every 256·N clocks. It is high for exactly D·N clocks starting in the first cycle of the period, and low for the rest.
- R4: A channel's waveform follows only the timebase named by its select field, whatever the state of its own index's timebase.
- R5: A channel whose output enable is 0 drives low, including when force-high is set.
- R6: An enabled channel with force-high set drives high regardless of duty, divider or run state.
- R7: A timebase whose run bit is 0 or whose divider is 0 holds its counters at zero. Every enabled, non-forced channel that follows it drives low.
- R8: A duty write changes the output in the cycle right after the write edge. A divider write that makes the current prescale count too large ends the current step on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwm_o | output | 4 | PWM outputs, bit c is channel c |

## Verification
The main function is swept over every channel with divider values 1 to 3 and duty levels 0, 1, 2, 128 and 255. The bench counts high cycles over a full 256·N window and checks the first and the wrap sample. This separates off-by-one faults in the prescaler, the step counter and the comparator. A cross-selected pattern runs only the chosen timebase, then only the channel's own timebase, so a channel wired to the wrong counter shows. Mid-period writes check that a lowered duty drops the output at once and that a shrunk divider cuts the current step short. The gating tests pair force-high with a disabled channel and pair a zero divider with run set, to tell enable, bypass and idle priority apart.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned CH_N     = 4;
  localparam int unsigned DIV_W    = 16;
  localparam int unsigned STEP_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  // register word offsets; software depends on these
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_RUN  = 'h04;
  localparam int unsigned OFS_DIV  = 'h08;
  localparam int unsigned OFS_DUTY = 'h18;
  localparam int unsigned BYP_LSB  = 8;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int unsigned N_CH   = CH_N,
  parameter int unsigned DW     = DIV_W,
  parameter int unsigned SW     = STEP_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned XW     = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [XW-1:0]             wdata_i,
  output logic [XW-1:0]             rdata_o,
  output logic [N_CH-1:0]           out_en_o,
  output logic [N_CH-1:0]           force_o,
  output logic [N_CH-1:0]           run_o,
  output logic [N_CH-1:0][DW-1:0]   div_o,
  output logic [N_CH-1:0][SW-1:0]   duty_o,
  output logic [N_CH-1:0][$clog2(N_CH)-1:0] sel_o
);
  localparam int unsigned SEL_W   = $clog2(N_CH);
  localparam int unsigned SEL_LSB = SW;

  logic [N_CH-1:0]            out_en_q, out_en_d;
  logic [N_CH-1:0]            force_q,  force_d;
  logic [N_CH-1:0]            run_q,    run_d;
  logic [N_CH-1:0][DW-1:0]    div_q,    div_d;
  logic [N_CH-1:0][SW-1:0]    duty_q,   duty_d;
  logic [N_CH-1:0][SEL_W-1:0] sel_q,    sel_d;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[XW-1:DW];

  // next-state decode
  always_comb begin
    out_en_d = out_en_q;
    force_d  = force_q;
    run_d    = run_q;
    div_d    = div_q;
    duty_d   = duty_q;
    sel_d    = sel_q;
    if (addr_i == AW'(OFS_CTRL)) begin
      out_en_d = wdata_i[N_CH-1:0];
      force_d  = wdata_i[BYP_LSB +: N_CH];
    end
    if (addr_i == AW'(OFS_RUN)) begin
      run_d = wdata_i[N_CH-1:0];
    end
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == AW'(OFS_DIV + 4*c)) begin
        div_d[c] = wdata_i[DW-1:0];
      end
      if (addr_i == AW'(OFS_DUTY + 4*c)) begin
        duty_d[c] = wdata_i[SW-1:0];
        sel_d[c]  = wdata_i[SEL_LSB +: SEL_W];
      end
    end
  end

  // register stage, clock enable = write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en_q <= '0;
      force_q  <= '0;
      run_q    <= '0;
      div_q    <= '0;
      duty_q   <= '0;
      sel_q    <= '0;
    end else if (we_i) begin
      out_en_q <= out_en_d;
      force_q  <= force_d;
      run_q    <= run_d;
      div_q    <= div_d;
      duty_q   <= duty_d;
      sel_q    <= sel_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_CTRL)) begin
      rdata_o[N_CH-1:0]          = out_en_q;
      rdata_o[BYP_LSB +: N_CH]   = force_q;
    end
    if (addr_i == AW'(OFS_RUN)) begin
      rdata_o[N_CH-1:0] = run_q;
    end
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == AW'(OFS_DIV + 4*c)) begin
        rdata_o[DW-1:0] = div_q[c];
      end
      if (addr_i == AW'(OFS_DUTY + 4*c)) begin
        rdata_o[SW-1:0]              = duty_q[c];
        rdata_o[SEL_LSB +: SEL_W]    = sel_q[c];
      end
    end
  end

  assign out_en_o = out_en_q;
  assign force_o  = force_q;
  assign run_o    = run_q;
  assign div_o    = div_q;
  assign duty_o   = duty_q;
  assign sel_o    = sel_q;

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(div_q) && $stable(duty_q) && $stable(sel_q) && $stable(run_q))); // R2
endmodule

// File: rtl/pwm4_timebase.sv
module pwm4_timebase
  import pwm4_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          active_o,
  output logic [SW-1:0] step_o
);
  logic [DW-1:0] presc_q, presc_d;
  logic [SW-1:0] step_q,  step_d;
  logic          wrap;

  assign active_o = run_i && (div_i != '0);
  // >= rather than == so a shrunk divider ends the step at once
  assign wrap     = presc_q >= (div_i - 1'b1);

  always_comb begin
    presc_d = presc_q;
    step_d  = step_q;
    if (!active_o) begin
      presc_d = '0;
      step_d  = '0;
    end else if (wrap) begin
      presc_d = '0;
      step_d  = step_q + 1'b1;
    end else begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      step_q  <= '0;
    end else begin
      presc_q <= presc_d;
      step_q  <= step_d;
    end
  end

  assign step_o = step_q;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> (step_q == '0 && presc_q == '0)); // R7
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && presc_q == div_i - 1'b1) |=> (step_q == SW'($past(step_q) + 1'b1))); // R3
  AST_SHRINK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && presc_q >= div_i) |=> (presc_q == '0)); // R8
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
#(
  parameter int unsigned SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          force_i,
  input  logic          active_i,
  input  logic [SW-1:0] step_i,
  input  logic [SW-1:0] duty_i,
  output logic          pwm_o
);
  logic below;

  assign below = step_i < duty_i;

  always_comb begin
    pwm_o = 1'b0;
    if (en_i) begin
      if (force_i) begin
        pwm_o = 1'b1;
      end else begin
        pwm_o = active_i && below;
      end
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_o); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && force_i) |-> pwm_o); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !active_i) |-> !pwm_o); // R7
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int unsigned N_CH = CH_N,
  parameter int unsigned DW   = DIV_W,
  parameter int unsigned SW   = STEP_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned XW   = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [XW-1:0] reg_wdata,
  output logic [XW-1:0] reg_rdata,
  output logic [N_CH-1:0] pwm_o
);
  localparam int unsigned SEL_W = $clog2(N_CH);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [N_CH-1:0]            out_en, force_hi, run;
  logic [N_CH-1:0][DW-1:0]    div;
  logic [N_CH-1:0][SW-1:0]    duty;
  logic [N_CH-1:0][SEL_W-1:0] sel;
  logic [N_CH-1:0]            tb_active;
  logic [N_CH-1:0][SW-1:0]    tb_step;

  pwm4_regs #(.N_CH(N_CH), .DW(DW), .SW(SW), .AW(AW), .XW(XW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .out_en_o (out_en),
    .force_o  (force_hi),
    .run_o    (run),
    .div_o    (div),
    .duty_o   (duty),
    .sel_o    (sel)
  );

  for (genvar t = 0; t < N_CH; t++) begin : g_tb
    pwm4_timebase #(.DW(DW), .SW(SW)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .run_i    (run[t]),
      .div_i    (div[t]),
      .active_o (tb_active[t]),
      .step_o   (tb_step[t])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm4_chan #(.SW(SW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .en_i     (out_en[c]),
      .force_i  (force_hi[c]),
      .active_i (tb_active[sel[c]]),
      .step_i   (tb_step[sel[c]]),
      .duty_i   (duty[c]),
      .pwm_o    (pwm_o[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> (pwm_o == '0)); // R1
endmodule

// File: tb/test_pwm4_ctrl.sv
module test_pwm4_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  pwm4_ctrl i_pwm4_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_o     (pwm_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // sample channel c for len cycles, starting now; return number of high samples
  task automatic measure(input int c, input int len, output int highs, output bit first);
    highs = 0;
    first = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (k == 0) first = pwm_o[c];
      if (pwm_o[c]) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int          highs;
    bit          first;
    int          duties[5] = '{0, 1, 2, 128, 255};

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 'h28; a += 4) begin
      rd(8'(a), d);
      chk($sformatf("R1 reset read @%0h", a), d, 0);
    end
    chk("R1 outputs low after reset", pwm_o, 0);

    // R2 readback masks and decode
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 ctrl mask", d, 32'h0F0F);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R2 run mask",  d, 32'h000F);
    wr(8'h00, 0); wr(8'h04, 0);
    for (int c = 0; c < 4; c++) begin
      wr(8'(8 + 4*c), 32'hFFFF_0000 | 32'(16'h1230 + c));
      wr(8'(24 + 4*c), 32'hFFFF_FC00 | 32'(((c ^ 1) << 8) | (8'h40 + c)));
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'(8 + 4*c), d);  chk($sformatf("R2 div%0d readback", c), d, 32'h1230 + c);
      rd(8'(24 + 4*c), d); chk($sformatf("R2 duty%0d readback", c), d, ((c ^ 1) << 8) | (32'h40 + c));
    end
    rd(8'h28, d); chk("R2 unmapped read zero", d, 0);
    rd(8'h02, d); chk("R2 unaligned read zero", d, 0);

    // R3 sweep over channels, dividers and duties
    for (int c = 0; c < 4; c++) begin
      for (int n = 1; n <= 3; n++) begin
        for (int i = 0; i < 5; i++) begin
          wr(8'h04, 0);
          wr(8'h00, 32'(1 << c));
          wr(8'(8 + 4*c), 32'(n));
          wr(8'(24 + 4*c), 32'((c << 8) | duties[i]));
          wr(8'h04, 32'(1 << c));
          measure(c, 256*n, highs, first);
          chk($sformatf("R3 ch%0d N=%0d D=%0d high time", c, n, duties[i]), highs, duties[i]*n);
          chk($sformatf("R3 ch%0d N=%0d D=%0d period start", c, n, duties[i]), first, duties[i] > 0);
          chk($sformatf("R3 ch%0d N=%0d D=%0d wrap sample", c, n, duties[i]), pwm_o[c], duties[i] > 0);
        end
      end
    end

    // R4 channel 0 follows timebase 3
    wr(8'h04, 0);
    wr(8'h0C, 0); wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h08, 7);
    wr(8'h14, 2);
    wr(8'h18, (3 << 8) | 10);
    wr(8'h00, 1);
    wr(8'h04, 32'h8);
    measure(0, 512, highs, first);
    chk("R4 ch0 on timebase3 high time", highs, 20);
    wr(8'h04, 0);
    wr(8'h04, 32'h1);
    measure(0, 100, highs, first);
    chk("R4 ch0 ignores own timebase", highs, 0);

    // R5 disabled channel with force-high stays low
    wr(8'h04, 0);
    for (int c = 0; c < 4; c++) begin
      wr(8'(8 + 4*c), 1);
      wr(8'(24 + 4*c), 32'((c << 8) | 255));
    end
    wr(8'h00, 32'h0F00);
    wr(8'h04, 32'hF);
    @(negedge clk);
    chk("R5 disabled outputs low", pwm_o, 0);

    // R6 forced high regardless of run and duty
    wr(8'h04, 0);
    for (int c = 0; c < 4; c++) wr(8'(24 + 4*c), 32'(c << 8));
    wr(8'h00, 32'h0F0F);
    @(negedge clk);
    chk("R6 force-high with run off and duty 0", pwm_o, 4'hF);

    // R7 zero divider or run clear gives low
    for (int c = 0; c < 4; c++) begin
      wr(8'(8 + 4*c), 0);
      wr(8'(24 + 4*c), 32'((c << 8) | 255));
    end
    wr(8'h00, 32'h000F);
    wr(8'h04, 32'hF);
    for (int c = 0; c < 4; c++) begin
      measure(c, 50, highs, first);
      chk($sformatf("R7 ch%0d divider zero low", c), highs, 0);
    end
    for (int c = 0; c < 4; c++) wr(8'(8 + 4*c), 1);
    wr(8'h04, 0);
    @(negedge clk);
    chk("R7 run clear low", pwm_o, 0);

    // R8 duty write acts in the next cycle
    wr(8'h04, 0);
    wr(8'h08, 1);
    wr(8'h18, 200);
    wr(8'h00, 1);
    wr(8'h04, 1);
    repeat (100) @(negedge clk);
    chk("R8 high before duty cut", pwm_o[0], 1);
    wr(8'h18, 50);
    chk("R8 duty cut immediate", pwm_o[0], 0);

    // R8 divider shrink ends the step on the next clock
    wr(8'h04, 0);
    wr(8'h08, 100);
    wr(8'h18, 1);
    wr(8'h04, 1);
    repeat (20) @(negedge clk);
    chk("R8 high in long first step", pwm_o[0], 1);
    wr(8'h08, 5);
    @(negedge clk);
    chk("R8 divider shrink ends step", pwm_o[0], 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule